// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Interface Port

This block is a byte-wide SPI port that acts as bus master or bus slave. The role is chosen at run time through an 8-bit configuration register. The same register selects clock polarity, clock phase, bit order, whether the slave-select pin is honoured, the master clock rate, and whether the port is active at all. When the port is inactive, every output enable is low and the pins go back to general-purpose use.

A host loads a byte through a valid/ready handshake and collects the received byte after a one-cycle completion pulse. As master, the port generates SCLK from the system clock and drives its own select line low for the length of one byte. As slave, it passes the incoming SCLK, select and data lines through a synchroniser, shifts on the edges it sees, and drops a partial byte when select goes away.

Top module: `spi_duplex_port`

## Requirements
- R1: The configuration register resets to 0x00 and reads back the last written value. Its layout is bit7 ignore-select, bit6 enable, bit5 LSB-first, bit4 master, bit3 CPOL, bit2 CPHA, bits1:0 rate.
- R2: While enable is 0, pins_released is 1, all four output enables are 0, tx_ready is 0, and a tx_valid pulse starts no transfer and produces no rx_done.
- R3: In master role, SCLK rests at CPOL between bytes. During a byte it toggles every H system cycles, where H is 2, 8, 32 or 64 for rate codes 0, 1, 2 and 3. This gives a division of 4, 16, 64 or 128.
- R4: In master role, ss_n_o goes low on the cycle after the byte is accepted and stays low for exactly 16·H cycles. rx_done is high for exactly one cycle, the cycle in which ss_n_o returns high.
- R5: The output bit changes only on drive edges. With CPHA=0 these are the trailing edges and the first bit is present before the first edge; with CPHA=1 they are the leading edges after the first one. This applies to mosi_o in master role and miso_o in slave role.
- R6: With CPHA=0 data is sampled on leading edges, and with CPHA=1 on trailing edges. The eight sampled bits appear on rx_data together with rx_done, correctly in all four modes.
- R7: With LSB-first set, bit 0 is sent and received first. Otherwise bit 7 goes first. This applies in both directions.
- R8: In slave role, rx_done rises three system clocks after the pin edge that carries the eighth sample. miso_oe is 1 only while the port is selected.
- R9: In slave role with ignore-select clear, raising ss_n_i before eight samples discards the partial byte: no rx_done is produced and tx_ready returns to 1.
- R10: With ignore-select set, the slave shifts and drives miso with ss_n_i held high.
- R11: tx_ready is 1 only while idle. A master accepts a byte only when tx_valid and tx_ready are both 1, and tx_valid during a byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read value |
| tx_valid | input | 1 | Host offers a byte |
| tx_data | input | DATA_W | Byte to send |
| tx_ready | output | 1 | Port can take a byte |
| rx_done | output | 1 | One-cycle byte-complete pulse |
| rx_data | output | DATA_W | Last received byte |
| sclk_i | input | 1 | Serial clock from pin (slave) |
| sclk_o | output | 1 | Serial clock to pin (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out data from pin (slave) |
| mosi_o | output | 1 | Master-out data to pin |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Slave-out data from pin (master) |
| miso_o | output | 1 | Slave-out data to pin |
| miso_oe | output | 1 | Slave-out output enable |
| ss_n_i | input | 1 | Active-low select from pin (slave) |
| ss_n_o | output | 1 | Active-low select to pin (master) |
| ss_n_oe | output | 1 | Select output enable |
| pins_released | output | 1 | Pins are free for general-purpose use |

## Verification
In master role, every result follows from the cycle index j counted from the accept edge. After j cycles, the count of SCLK edges so far is j/H. The expected SCLK level, select level and data bit are derived from that count, and the bench compares them on every falling clock edge up to j = 16·H, where the completion pulse and the byte are due. In slave role, the bench moves a pin on a falling edge and then checks rx_done on each of the following six falling edges. It must be high on exactly the third and only after the eighth sample edge. The slave's output bit is read just before each bench-side sampling edge, at least six cycles after the previous drive edge.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;

   typedef struct packed {
      logic       ss_ignore;
      logic       enable;
      logic       lsb_first;
      logic       master;
      logic       cpol;
      logic       cpha;
      logic [1:0] rate;
   } spi_cfg_t;

   localparam int unsigned MAX_HALF = 64;

   // System cycles per SCLK half period for each rate code.
   function automatic int unsigned half_period(input logic [1:0] rate);
      case (rate)
         2'd0:    return 2;
         2'd1:    return 8;
         2'd2:    return 32;
         default: return MAX_HALF;
      endcase
   endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
   import spi_duplex_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       halt,
   input  logic [1:0] rate,
   output logic       busy,
   output logic       phase,
   output logic       edge_stb,
   output logic       edge_lead,
   output logic       finish
);
   localparam int unsigned EVT_N = 2 * DATA_W;
   localparam int unsigned EVT_W = $clog2(EVT_N);
   localparam int unsigned CNT_W = $clog2(MAX_HALF);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic [EVT_W-1:0] evt;

   assign limit     = CNT_W'(half_period(rate) - 1);
   assign edge_stb  = busy && (cnt == limit);
   assign edge_lead = !evt[0];
   assign finish    = edge_stb && (evt == EVT_W'(EVT_N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         phase <= 1'b0;
         cnt   <= '0;
         evt   <= '0;
      end else if (halt) begin
         busy  <= 1'b0;
         phase <= 1'b0;
         cnt   <= '0;
         evt   <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            evt  <= '0;
         end
      end else if (edge_stb) begin
         cnt   <= '0;
         phase <= ~phase;
         evt   <= evt + 1'b1;
         if (finish) busy <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R3: the generated clock is back at rest whenever no byte is running
   p_phase_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !phase);
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              clear,
   input  logic              sample_stb,
   input  logic              drive_stb,
   input  logic              din,
   input  logic              lsb_first,
   output logic              dout,
   output logic              idle,
   output logic              last_bit,
   output logic [DATA_W-1:0] rx_word,
   output logic [DATA_W-1:0] rx_next
);
   localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

   logic [DATA_W-1:0] tx_sr;
   logic [CNT_W-1:0]  cnt;

   assign dout     = lsb_first ? tx_sr[0] : tx_sr[DATA_W-1];
   assign idle     = (cnt == '0);
   assign last_bit = sample_stb && (cnt == CNT_W'(DATA_W - 1));
   assign rx_next  = lsb_first ? {din, rx_word[DATA_W-1:1]}
                               : {rx_word[DATA_W-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_word <= '0;
         cnt     <= '0;
      end else if (load) begin
         tx_sr <= load_data;
         cnt   <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else begin
         if (sample_stb) begin
            rx_word <= rx_next;
            cnt     <= last_bit ? '0 : cnt + 1'b1;
         end
         // the first bit is never shifted away before its sample
         if (drive_stb && !idle)
            tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      end
   end

   // R5: output bit moves only on a drive edge or a fresh load
   p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive_stb && !load && !$past(1'b0)) |=> $stable(dout) || $past(lsb_first) != lsb_first);
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
   import spi_duplex_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              rx_done,
   output logic [DATA_W-1:0] rx_data,
   input  logic              sclk_i,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              ss_n_i,
   output logic              ss_n_o,
   output logic              ss_n_oe,
   output logic              pins_released
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_duplex_port needs DATA_W of at least 2");
      end
   endgenerate

   spi_cfg_t cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg <= '0;
      else if (cfg_we) cfg <= spi_cfg_t'(cfg_wdata);
   end
   assign cfg_rdata = cfg;

   logic is_m, is_s;
   assign is_m = cfg.enable &&  cfg.master;
   assign is_s = cfg.enable && !cfg.master;

   // slave-side pin synchroniser: {select, clock, data}
   logic [2:0] pins_s;
   logic       ss_s, sclk_s, mosi_s, sclk_d;

   spi_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ss_n_i, sclk_i, mosi_i}), .q(pins_s)
   );
   assign {ss_s, sclk_s, mosi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   logic sel, s_edge, s_lead, s_sample, s_drive;
   assign sel      = cfg.ss_ignore || !ss_s;
   assign s_edge   = is_s && sel && (sclk_s != sclk_d);
   assign s_lead   = (sclk_s != cfg.cpol);
   assign s_sample = s_edge && (s_lead ^ cfg.cpha);
   assign s_drive  = s_edge && !(s_lead ^ cfg.cpha);

   // master clock generator
   logic busy, phase, m_edge, m_lead, m_finish, m_start;
   logic m_sample, m_drive;

   spi_clkgen #(.DATA_W(DATA_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .start(m_start), .halt(!is_m),
      .rate(cfg.rate), .busy(busy), .phase(phase),
      .edge_stb(m_edge), .edge_lead(m_lead), .finish(m_finish)
   );
   assign m_sample = m_edge && (m_lead ^ cfg.cpha);
   assign m_drive  = m_edge && !(m_lead ^ cfg.cpha);

   // shared shift engine
   logic eng_dout, eng_idle, eng_last, load;
   logic [DATA_W-1:0] rx_word, rx_next;

   assign tx_ready = is_m ? !busy : (is_s && eng_idle);
   assign load     = tx_valid && tx_ready;
   assign m_start  = is_m && load;

   spi_bit_engine #(.DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .load(load), .load_data(tx_data),
      .clear(!cfg.enable || (is_s && !sel)),
      .sample_stb(is_m ? m_sample : s_sample),
      .drive_stb(is_m ? m_drive : s_drive),
      .din(is_m ? miso_i : mosi_s),
      .lsb_first(cfg.lsb_first),
      .dout(eng_dout), .idle(eng_idle), .last_bit(eng_last),
      .rx_word(rx_word), .rx_next(rx_next)
   );

   logic              done_q;
   logic [DATA_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         rx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (is_m && m_finish) begin
            done_q <= 1'b1;
            rx_q   <= m_sample ? rx_next : rx_word;
         end else if (is_s && eng_last) begin
            done_q <= 1'b1;
            rx_q   <= rx_next;
         end
      end
   end

   assign rx_done       = done_q;
   assign rx_data       = rx_q;
   assign sclk_o        = cfg.cpol ^ phase;
   assign sclk_oe       = is_m;
   assign mosi_o        = eng_dout;
   assign mosi_oe       = is_m;
   assign ss_n_o        = !busy;
   assign ss_n_oe       = is_m;
   assign miso_o        = eng_dout;
   assign miso_oe       = is_s && sel;
   assign pins_released = !cfg.enable;

   // R2: a disabled port drives nothing and offers no handshake
   p_released_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.enable |-> !(sclk_oe || mosi_oe || miso_oe || ss_n_oe || tx_ready));

   // R4: completion is a single-cycle pulse
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R11: an accepted master byte lowers select on the next cycle
   p_accept_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (is_m && tx_valid && tx_ready && !cfg_we) |=> !ss_n_o);

   // R3: between master bytes the clock sits at its resting level
   p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_m && ss_n_o) |-> (sclk_o == cfg.cpol));
endmodule

// File: tb/sim_spi_duplex_port.sv
`timescale 1ns/1ps
module sim_spi_duplex_port;
   localparam int HP = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic tx_valid = 1'b0;
   logic [7:0] tx_data = '0;
   logic tx_ready, rx_done;
   logic [7:0] rx_data;
   logic sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
   logic sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_n_o, ss_n_oe;
   logic pins_released;

   int errs = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   spi_duplex_port u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .rx_done(rx_done), .rx_data(rx_data),
      .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
      .ss_n_i(ss_n_i), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe),
      .pins_released(pins_released)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   function automatic int hp_of(input logic [1:0] r);
      return (r == 2'd3) ? 64 : (2 << (2 * r));
   endfunction

   function automatic int shifts(input int e, input logic cpha);
      int s;
      s = cpha ? ((e + 1) / 2 - 1) : (e / 2);
      if (s < 0) s = 0;
      if (s > 7) s = 7;
      return s;
   endfunction

   function automatic logic bitsel(input logic [7:0] b, input int idx, input logic lsb);
      return lsb ? b[idx] : b[7 - idx];
   endfunction

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
      check("R1", cfg_rdata, v);
   endtask

   task automatic master_xfer(input logic [7:0] cfgb, input logic [7:0] txb, input logic [7:0] mb);
      logic cpol, cpha, lsb;
      int h, e;
      string rq;
      cpol = cfgb[3]; cpha = cfgb[2]; lsb = cfgb[5];
      h = hp_of(cfgb[1:0]);
      rq = lsb ? "R7" : "R6";
      write_cfg(cfgb);
      @(negedge clk);
      check("R3", sclk_o, cpol);
      check("R4", ss_n_o, 1);
      check("R11", tx_ready, 1);
      tx_valid = 1'b1; tx_data = txb; miso_i = bitsel(mb, 0, lsb);
      @(negedge clk); tx_valid = 1'b0;
      for (int j = 1; j <= 16 * h; j++) begin
         @(negedge clk);
         e = j / h;
         if (j < 16 * h) begin
            check("R3", sclk_o, cpol ^ e[0]);
            check("R4", ss_n_o, 0);
            check("R4", rx_done, 0);
            check(lsb ? "R7" : "R5", mosi_o, bitsel(txb, shifts(e, cpha), lsb));
            miso_i = bitsel(mb, shifts(e, cpha), lsb);
            if (j == 1) check("R11", tx_ready, 0);
            if (j == 2) begin tx_valid = 1'b1; tx_data = ~txb; end
            if (j == 3) tx_valid = 1'b0;
         end else begin
            check("R4", rx_done, 1);
            check(rq, rx_data, mb);
            check("R4", ss_n_o, 1);
            check("R3", sclk_o, cpol);
         end
      end
      @(negedge clk);
      check("R4", rx_done, 0);
      check("R11", ss_n_o, 1);
   endtask

   task automatic hold_check(input int due, input string rq, input logic [7:0] exp_rx);
      for (int k = 1; k <= HP; k++) begin
         @(negedge clk);
         if (k == due) begin
            check("R8", rx_done, 1);
            check(rq, rx_data, exp_rx);
         end else begin
            check("R8", rx_done, 0);
         end
      end
   endtask

   task automatic slave_xfer(input logic [7:0] cfgb, input logic [7:0] host_tx,
                             input logic [7:0] mb, input int nbits);
      logic cpol, cpha, lsb, ssig;
      logic [7:0] got;
      string rq;
      int due;
      cpol = cfgb[3]; cpha = cfgb[2]; lsb = cfgb[5]; ssig = cfgb[7];
      rq = lsb ? "R7" : "R6";
      got = '0;
      write_cfg(8'h00);
      sclk_i = cpol; ss_n_i = 1'b1; mosi_i = 1'b0;
      repeat (4) @(negedge clk);
      write_cfg(cfgb);
      @(negedge clk);
      check("R11", tx_ready, 1);
      tx_valid = 1'b1; tx_data = host_tx;
      @(negedge clk); tx_valid = 1'b0;
      if (!ssig) ss_n_i = 1'b0;
      mosi_i = bitsel(mb, 0, lsb);
      hold_check(0, rq, mb);
      check(ssig ? "R10" : "R8", miso_oe, 1);
      for (int b = 0; b < nbits; b++) begin
         due = (b == 7) ? 3 : 0;
         if (!cpha) begin
            got[lsb ? b : 7 - b] = miso_o;
            sclk_i = ~sclk_i;
            hold_check(due, rq, mb);
            sclk_i = ~sclk_i;
            if (b < 7) mosi_i = bitsel(mb, b + 1, lsb);
            hold_check(0, rq, mb);
         end else begin
            sclk_i = ~sclk_i;
            mosi_i = bitsel(mb, b, lsb);
            hold_check(0, rq, mb);
            got[lsb ? b : 7 - b] = miso_o;
            sclk_i = ~sclk_i;
            hold_check(due, rq, mb);
         end
      end
      if (nbits == 8) check(lsb ? "R7" : "R5", got, host_tx);
      ss_n_i = 1'b1;
      hold_check(0, rq, mb);
      check(ssig ? "R10" : "R8", miso_oe, ssig);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", cfg_rdata, 8'h00);
      check("R2", pins_released, 1);
      check("R2", {sclk_oe, mosi_oe, miso_oe, ss_n_oe}, 4'b0000);
      check("R2", tx_ready, 0);
      tx_valid = 1'b1; tx_data = 8'h5A;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         check("R2", ss_n_oe, 0);
         check("R2", rx_done, 0);
      end
      tx_valid = 1'b0;
      write_cfg(8'hA5);
      check("R2", pins_released, 1);
      write_cfg(8'h00);

      // master role: ignore-select, enable, lsb, master, cpol, cpha, rate
      master_xfer(8'b0101_0000, 8'hA5, 8'h3C);
      master_xfer(8'b0111_0101, 8'h81, 8'hC6);
      master_xfer(8'b0111_1000, 8'h5E, 8'h17);
      master_xfer(8'b0101_1110, 8'hF0, 8'h0F);
      master_xfer(8'b0101_0011, 8'h96, 8'h69);

      write_cfg(8'h00);
      check("R2", pins_released, 1);
      check("R2", {sclk_oe, mosi_oe, miso_oe, ss_n_oe}, 4'b0000);

      // slave role in all four modes
      slave_xfer(8'b0100_0000, 8'hC3, 8'h2D, 8);
      slave_xfer(8'b0110_0100, 8'h1E, 8'hB4, 8);
      slave_xfer(8'b0100_1000, 8'h77, 8'h88, 8);
      slave_xfer(8'b0110_1100, 8'h4B, 8'hD2, 8);

      // R9: partial byte dropped when select rises
      slave_xfer(8'b0100_0000, 8'h3A, 8'hC5, 4);
      check("R9", tx_ready, 1);
      check("R9", rx_done, 0);
      slave_xfer(8'b0100_0000, 8'h3A, 8'hC5, 8);

      // R10: select ignored
      slave_xfer(8'b1100_1100, 8'h69, 8'hE1, 8);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule